// File: doc/BRIEF.md
# Multi-Rail Reset Supervisor Logic

This block is the digital decision logic that sits behind a three-rail supply monitor. Three analog comparators each report whether their rail is above its trip point. A board-level pushbutton or host line provides an active-low manual reset request. The block combines these four inputs and drives one system reset in two polarities, active-low and active-high.

Reset is raised as soon as a qualified fault is seen on any input. It is held for as long as any fault persists. The release comes only after a fixed hold-off time has run out, and that time is counted on the free-running clock from the moment the last fault has cleared. If a new fault arrives during the hold-off, the count starts over from zero. All inputs are asynchronous. Each one first passes through a two-stage synchronizer and then through a minimum-width qualifier, so that pulses too short to matter are ignored.

Timing is set from physical quantities: the clock frequency, the hold-off time in microseconds, and the minimum fault widths in nanoseconds for the rails and for the manual input. Each is converted to a cycle count, rounded up and never below one. In what follows, NS is the rail qualification count, NM is the manual-reset qualification count and D is the hold-off count.

Top module: `rail_reset_supervisor`

## Requirements
- R1: A rail-good input held low for at least NS clock cycles drives reset active, whatever the other inputs show. The output changes exactly 3+NS rising edges after the input falls (2 synchronizer stages, NS qualification samples, 1 output register).
- R2: A manual reset input held low for at least NM cycles drives reset active, whatever the rail inputs show. The output changes exactly 3+NM edges after the input falls.
- R3: Reset stays active while any qualified fault persists. For every one of the 16 combinations of the four inputs, the output settles to active unless all three rails are good and manual reset is high.
- R4: Once every input is good again, reset is released exactly 3+D rising edges after the last input returns high. D is ceil(CLK_HZ·DELAY_US/10^6).
- R5: A qualified fault on any input during the hold-off clears the count and keeps reset active. The release then comes 3+D edges after that fault clears.
- R6: The two outputs are always complementary: the active-low output equals the inverse of the active-high output.
- R7: A rail-good low pulse that is shorter than NS cycles has no effect. A released output stays released, and a hold-off that is running is not restarted.
- R8: A manual-reset low pulse that is shorter than NM cycles has no effect, either on a released output or on a running hold-off.
- R9: While the block's own reset is high, reset is active and the hold-off count is zero. With all inputs good, the release comes exactly D rising edges after the first edge at which the block reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock used for counting |
| rst | input | 1 | Synchronous active-high reset of the block itself |
| rail_ok_i | input | NUM_RAILS | Asynchronous comparator outputs, high when the rail is above threshold |
| man_rst_n_i | input | 1 | Asynchronous manual reset request, active low |
| sys_rst_n_o | output | 1 | System reset, active low |
| sys_rst_o | output | 1 | System reset, active high |

## Verification
Every input change is applied on a falling clock edge and every output is sampled on a falling edge, so each result can be tied to an exact count of rising edges. A fault is due 3+NS edges (rail) or 3+NM edges (manual) after the input falls. The bench samples one edge before that point, expecting no change, and then on the due edge itself. A release is due 3+D edges after the last input recovers; the bench checks at 2+D edges (still active) and at 3+D (released). The same two-point bracket is used for the restart, short-glitch and post-reset cases, and the exhaustive input sweep lets 12 edges settle before it compares.

// File: rtl/rail_sup_pkg.sv
package rail_sup_pkg;

  // Convert a duration in nanoseconds to clock cycles, rounded up, minimum 1.
  function automatic int unsigned ns_to_cycles(longint unsigned hz, longint unsigned ns);
    longint unsigned c;
    c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  // Width needed for a counter that runs from 0 to n-1 (minimum 1 bit).
  function automatic int unsigned cnt_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int unsigned     W       = 4,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/rs_pulse_qual.sv
module rs_pulse_qual #(
  parameter int unsigned MIN_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ok_i,
  output logic flt_o
);
  import rail_sup_pkg::*;
  localparam int unsigned   CW   = cnt_width(MIN_CYC);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] run_q;

  // The fault is flagged once ok_i has been sampled low on MIN_CYC consecutive edges.
  // It is dropped on the first high sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      flt_o <= 1'b0;
    end else if (ok_i) begin
      run_q <= '0;
      flt_o <= 1'b0;
    end else if (run_q == LAST) begin
      flt_o <= 1'b1;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/rs_release_timer.sv
module rs_release_timer #(
  parameter int unsigned DELAY_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fault_i,
  output logic rst_o,
  output logic rst_n_o
);
  import rail_sup_pkg::*;
  localparam int unsigned   CW   = cnt_width(DELAY_CYC);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic [CW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      rst_o   <= 1'b1;
      rst_n_o <= 1'b0;
    end else if (fault_i) begin
      hold_q  <= '0;
      rst_o   <= 1'b1;
      rst_n_o <= 1'b0;
    end else if (rst_o) begin
      if (hold_q == LAST) begin
        rst_o   <= 1'b0;
        rst_n_o <= 1'b1;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rail_reset_supervisor.sv
module rail_reset_supervisor #(
  parameter int unsigned NUM_RAILS    = 3,
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned DELAY_US     = 200_000,
  parameter int unsigned SENSE_MIN_NS = 6_000,
  parameter int unsigned MR_MIN_NS    = 100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_RAILS-1:0] rail_ok_i,
  input  logic                 man_rst_n_i,
  output logic                 sys_rst_n_o,
  output logic                 sys_rst_o
);
  import rail_sup_pkg::*;

  localparam int unsigned NCH       = NUM_RAILS + 1;
  localparam int unsigned SENSE_CYC = ns_to_cycles(CLK_HZ, SENSE_MIN_NS);
  localparam int unsigned MR_CYC    = ns_to_cycles(CLK_HZ, MR_MIN_NS);
  localparam int unsigned DELAY_CYC = ns_to_cycles(CLK_HZ, longint'(DELAY_US) * 1000);

  // Bit NUM_RAILS of each vector is the manual reset; the lower bits are the rails.
  // Every bit is low when its channel reports a fault.
  logic [NCH-1:0] sync_ok;
  logic [NCH-1:0] qual_flt;

  rs_sync #(
    .W       (NCH),
    .RST_VAL ({NCH{1'b1}})
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({man_rst_n_i, rail_ok_i}),
    .q_o (sync_ok)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_qual
    localparam int unsigned MIN_C = (g == NUM_RAILS) ? MR_CYC : SENSE_CYC;
    rs_pulse_qual #(
      .MIN_CYC (MIN_C)
    ) u_qual (
      .clk   (clk),
      .rst   (rst),
      .ok_i  (sync_ok[g]),
      .flt_o (qual_flt[g])
    );
  end

  rs_release_timer #(
    .DELAY_CYC (DELAY_CYC)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .fault_i (|qual_flt),
    .rst_o   (sys_rst_o),
    .rst_n_o (sys_rst_n_o)
  );
endmodule

// File: rtl/rail_reset_supervisor_chk.sv
module rail_reset_supervisor_chk #(
  parameter int unsigned NUM_RAILS = 3,
  parameter int unsigned SENSE_CYC = 4,
  parameter int unsigned MR_CYC    = 2,
  parameter int unsigned DELAY_CYC = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_RAILS:0]   sync_ok,
  input logic [NUM_RAILS:0]   qual_flt,
  input logic                 sys_rst_o,
  input logic                 sys_rst_n_o
);
  localparam int unsigned QW   = $clog2(DELAY_CYC + 1);
  localparam int unsigned MAXP = (SENSE_CYC > MR_CYC) ? SENSE_CYC : MR_CYC;
  localparam int unsigned LW   = $clog2(MAXP + 1);

  // Consecutive fault-free cycles, saturating at DELAY_CYC.
  logic [QW-1:0] quiet_q;
  always_ff @(posedge clk) begin
    if (rst || (|qual_flt)) quiet_q <= '0;
    else if (quiet_q != QW'(DELAY_CYC)) quiet_q <= quiet_q + 1'b1;
  end

  assert_fault_forces_reset_R1: assert property (@(posedge clk) disable iff (rst)
    (|qual_flt) |=> sys_rst_o);

  assert_stay_released_R3: assert property (@(posedge clk) disable iff (rst)
    (!sys_rst_o && !(|qual_flt)) |=> !sys_rst_o);

  assert_release_delay_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_o) |-> (quiet_q >= QW'(DELAY_CYC)));

  for (genvar g = 0; g <= NUM_RAILS; g++) begin : g_chan
    localparam int unsigned MIN_C = (g == NUM_RAILS) ? MR_CYC : SENSE_CYC;
    logic [LW-1:0] low_q;
    always_ff @(posedge clk) begin
      if (rst || sync_ok[g]) low_q <= '0;
      else if (low_q != LW'(MAXP)) low_q <= low_q + 1'b1;
    end

    assert_flag_drops_R3: assert property (@(posedge clk) disable iff (rst)
      sync_ok[g] |=> !qual_flt[g]);

    if (g == NUM_RAILS) begin : g_mr
      assert_mr_min_width_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(qual_flt[g]) |-> (low_q >= LW'(MIN_C)));
    end else begin : g_rail
      assert_rail_min_width_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(qual_flt[g]) |-> (low_q >= LW'(MIN_C)));
    end
  end
endmodule

bind rail_reset_supervisor rail_reset_supervisor_chk #(
  .NUM_RAILS (NUM_RAILS),
  .SENSE_CYC (SENSE_CYC),
  .MR_CYC    (MR_CYC),
  .DELAY_CYC (DELAY_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sync_ok     (sync_ok),
  .qual_flt    (qual_flt),
  .sys_rst_o   (sys_rst_o),
  .sys_rst_n_o (sys_rst_n_o)
);

// File: tb/test_rail_reset_supervisor.sv
module test_rail_reset_supervisor;
  // 1 MHz settings: hold-off 40 cycles, rail qualification 6, manual qualification 3.
  localparam int NS = 6;
  localparam int NM = 3;
  localparam int D  = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rail_ok = 3'b111;
  logic       mr_n = 1'b1;
  logic       rst_n_o, rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rail_reset_supervisor #(
    .NUM_RAILS    (3),
    .CLK_HZ       (1_000_000),
    .DELAY_US     (D),
    .SENSE_MIN_NS (NS * 1000),
    .MR_MIN_NS    (NM * 1000)
  ) i_rail_reset_supervisor (
    .clk         (clk),
    .rst         (rst),
    .rail_ok_i   (rail_ok),
    .man_rst_n_i (mr_n),
    .sys_rst_n_o (rst_n_o),
    .sys_rst_o   (rst_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Checks both outputs; complementarity (R6) is part of every check.
  task automatic chk(input string req, input logic exp);
    checks++;
    if (rst_o !== exp || rst_n_o !== ~exp) begin
      errors++;
      $display("FAIL %s: actual rst=%b rst_n=%b expected rst=%b rst_n=%b (R6 pair)",
               req, rst_o, rst_n_o, exp, ~exp);
    end
  endtask

  task automatic all_good();
    rail_ok = 3'b111;
    mr_n    = 1'b1;
  endtask

  // After the last input has recovered: still active at 2+D edges, released at 3+D.
  task automatic expect_release(input string req);
    step(2 + D); chk(req, 1'b1);
    step(1);     chk(req, 1'b0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R4: watchdog expired, actual still running, expected finished");
      report();
    end
  end

  initial begin
    // R9: reset state and release after block reset
    step(3);
    chk("R9 reset state", 1'b1);
    rst = 1'b0;
    step(D - 1); chk("R9 still active", 1'b1);
    step(1);     chk("R9 released", 1'b0);

    // R1: rail fault latency, then hold (R3) and release (R4)
    rail_ok[0] = 1'b0;
    step(2 + NS); chk("R1 before due edge", 1'b0);
    step(1);      chk("R1 due edge", 1'b1);
    step(10);     chk("R3 held", 1'b1);
    all_good();
    expect_release("R4 after rail");

    // R2: manual reset latency and release
    mr_n = 1'b0;
    step(2 + NM); chk("R2 before due edge", 1'b0);
    step(1);      chk("R2 due edge", 1'b1);
    all_good();
    expect_release("R4 after manual");

    // R3: exhaustive sweep of the four inputs
    for (int c = 0; c < 16; c++) begin
      rail_ok = c[2:0];
      mr_n    = c[3];
      step(12);
      chk($sformatf("R3 combo %0d", c), (c != 15));
      all_good();
      if (c != 15) expect_release("R4 sweep");
      else begin step(1); chk("R3 all good", 1'b0); end
    end

    // R7: short rail pulse ignored, qualifying pulse triggers
    rail_ok[1] = 1'b0; step(NS - 1); rail_ok[1] = 1'b1;
    for (int k = 0; k < 12; k++) begin step(1); chk("R7 short pulse", 1'b0); end
    rail_ok[1] = 1'b0; step(NS); rail_ok[1] = 1'b1;
    step(3);     chk("R7 full pulse", 1'b1);
    step(D - 1); chk("R7 hold", 1'b1);
    step(1);     chk("R7 release", 1'b0);

    // R8: short manual pulse ignored, qualifying pulse triggers
    mr_n = 1'b0; step(NM - 1); mr_n = 1'b1;
    for (int k = 0; k < 10; k++) begin step(1); chk("R8 short pulse", 1'b0); end
    mr_n = 1'b0; step(NM); mr_n = 1'b1;
    step(3);     chk("R8 full pulse", 1'b1);
    step(D - 1); chk("R8 hold", 1'b1);
    step(1);     chk("R8 release", 1'b0);

    // R5: rail fault during hold-off restarts the count
    rail_ok[2] = 1'b0; step(12); all_good();
    step(20); chk("R5 mid hold-off", 1'b1);
    rail_ok[0] = 1'b0; step(NS + 2); all_good();
    expect_release("R5 restart rail");

    // R5: manual fault during hold-off restarts the count
    rail_ok[1] = 1'b0; step(12); all_good();
    step(30); chk("R5 mid hold-off", 1'b1);
    mr_n = 1'b0; step(NM + 1); all_good();
    expect_release("R5 restart manual");

    // R7/R8: short glitches during hold-off do not restart it
    rail_ok[2] = 1'b0; step(12); all_good();
    step(10);
    rail_ok[0] = 1'b0; step(NS - 1); rail_ok[0] = 1'b1;
    mr_n = 1'b0; step(NM - 1); mr_n = 1'b1;
    // elapsed since recovery: 10 + (NS-1) + (NM-1) edges
    step(2 + D - 10 - (NS - 1) - (NM - 1)); chk("R7 R8 no restart", 1'b1);
    step(1); chk("R7 R8 no restart release", 1'b0);

    step(5);
    report();
  end
endmodule